// File: doc/BRIEF.md
# Serial Port Interrupt Event Controller

This block collects single-cycle event pulses from a serial port and latches each one into a raw status bit. The raw bits are gated by a software-written enable mask, and the OR of the gated bits drives one registered interrupt line to the processor. A small register port gives software four things. It can read and write the enable mask. It can read the status either unfiltered or filtered by the mask. It can clear latched events by writing ones. It can program the fill threshold that raises the receive-level event.

There are nine sources, one per status bit:

| Bit | Event |
|-----|-------|
| 0 | transmit DMA complete |
| 1 | receive DMA complete |
| 2 | port idle |
| 3 | transmit FIFO empty |
| 4 | transmit FIFO request |
| 5 | receive level reached |
| 6 | receive timeout |
| 7 | parity error |
| 8 | receive overflow |

Bit 5 is produced inside the block. A two-state machine compares the receive FIFO fill count with the threshold.

- In state `LV_BELOW`, the transition `LV_BELOW -> LV_REACHED` is taken when the count is at or above the threshold. This transition emits one level-hit pulse.
- In state `LV_REACHED`, the transition `LV_REACHED -> LV_BELOW` is taken when the count falls below the threshold. No pulse is emitted.

An external pulse on `evt_i[5]` also sets bit 5.

Register addresses:

| Address | Register | Access |
|---------|----------|--------|
| 0 | mask | read/write |
| 1 | raw status | read-only |
| 2 | masked status | read-only |
| 3 | clear | write-only, reads 0 |
| 4 | threshold | read/write |

Reads are combinational from the registers.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset, the mask reads 0, the raw status reads 0, the threshold reads 1 and `irq_o` is 0.
- R2: A pulse on `evt_i[i]` sets raw bit i at that clock edge. The bit reads 1 from the next cycle until it is cleared.
- R3: The raw status view (address 1) shows latched events regardless of the mask.
- R4: The masked status view (address 2) equals raw status AND mask.
- R5: `irq_o` is the OR of the masked status, registered once. Events whose mask bit is 0 never raise it.
- R6: Writing address 3 clears every raw bit written as 1 and leaves bits written as 0 unchanged. Address 3 reads 0.
- R7: When an event pulse and a clear of the same bit fall in one cycle, the bit ends up set.
- R8: After a bit has been cleared, a new pulse on that source latches it again.
- R9: Raw bit 5 is set in the cycle the state machine moves from below to reached, that is when the fill count first satisfies count >= threshold. While the count stays at or above the threshold, the event is not raised again. Dropping below the threshold re-arms it.
- R10: The mask (address 0, 9 bits) and the threshold (address 4, low `CNT_W` bits) read back what was written.
- R11: Writes to addresses 1 and 2 have no effect. Addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| evt_i | input | 9 | event pulses, one per status bit |
| rx_fill_i | input | CNT_W | receive FIFO fill count |
| reg_addr_i | input | 3 | register address |
| reg_wr_i | input | 1 | write strobe |
| reg_wdata_i | input | 9 | write data |
| reg_rdata_o | output | 9 | read data for `reg_addr_i` |
| irq_o | output | 1 | interrupt to the processor |

## Verification
The bench raises a pulse and a clear on the same bit in the same cycle. A design where clear takes priority would read that bit back as 0. It clears the receive-level event while the fill count still sits above the threshold. A level-sensitive design would set the bit again at once, and a design that never re-arms would miss the later crossing. It writes to the read-only status addresses, where a careless decoder would corrupt the latched events. It also checks that sources with their mask bit off leave the interrupt low while still showing in the raw view.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
    localparam int N_EVT     = 9;
    localparam int ADDR_W    = 3;
    localparam int EV_RX_LVL = 5;

    typedef enum logic [ADDR_W-1:0] {
        RA_MASK = 3'd0,
        RA_RAW  = 3'd1,
        RA_MSKD = 3'd2,
        RA_CLR  = 3'd3,
        RA_THR  = 3'd4
    } reg_addr_e;

    typedef enum logic {
        LV_BELOW   = 1'b0,
        LV_REACHED = 1'b1
    } lvl_state_e;
endpackage

// File: rtl/evt_lvl_fsm.sv
module evt_lvl_fsm
    import evt_irq_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] fill_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             hit_o
);
    lvl_state_e state_q, state_d;
    logic       at_or_above;

    assign at_or_above = (fill_i >= thr_i);

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= LV_BELOW;
        else         state_q <= state_d;
    end

    // next state and crossing pulse
    always_comb begin
        state_d = state_q;
        hit_o   = 1'b0;
        unique case (state_q)
            LV_BELOW: begin
                if (at_or_above) begin
                    state_d = LV_REACHED;
                    hit_o   = 1'b1;
                end
            end
            LV_REACHED: begin
                if (!at_or_above) state_d = LV_BELOW;
            end
        endcase
    end
endmodule

// File: rtl/evt_latch.sv
module evt_latch #(
    parameter int N = 9
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] raw_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)       raw_o[i] <= 1'b0;
            else if (set_i[i]) raw_o[i] <= 1'b1;   // set beats clear
            else if (clr_i[i]) raw_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
    import evt_irq_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int THR_RST = 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N_EVT-1:0]  evt_i,
    input  logic [CNT_W-1:0]  rx_fill_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [N_EVT-1:0]  reg_wdata_i,
    output logic [N_EVT-1:0]  reg_rdata_o,
    output logic              irq_o
);
    localparam int PAD_W = N_EVT - CNT_W;

    logic [N_EVT-1:0] mask_q;
    logic [CNT_W-1:0] thr_q;
    logic [N_EVT-1:0] raw_q;
    logic [N_EVT-1:0] set_vec;
    logic [N_EVT-1:0] clr_vec;
    logic [N_EVT-1:0] masked;
    logic             lvl_hit;
    logic             irq_q;
    logic             wr_mask, wr_thr;

    evt_lvl_fsm #(.CNT_W(CNT_W)) u_lvl (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .fill_i (rx_fill_i),
        .thr_i  (thr_q),
        .hit_o  (lvl_hit)
    );

    always_comb begin
        set_vec            = evt_i;
        set_vec[EV_RX_LVL] = evt_i[EV_RX_LVL] | lvl_hit;
    end

    assign wr_mask = reg_wr_i && (reg_addr_i == RA_MASK);
    assign wr_thr  = reg_wr_i && (reg_addr_i == RA_THR);
    assign clr_vec = (reg_wr_i && (reg_addr_i == RA_CLR)) ? reg_wdata_i : '0;

    evt_latch #(.N(N_EVT)) u_latch (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (set_vec),
        .clr_i  (clr_vec),
        .raw_o  (raw_q)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mask_q <= '0;
            thr_q  <= CNT_W'(THR_RST);
        end else begin
            if (wr_mask) mask_q <= reg_wdata_i;
            if (wr_thr)  thr_q  <= reg_wdata_i[CNT_W-1:0];
        end
    end

    assign masked = raw_q & mask_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) irq_q <= 1'b0;
        else         irq_q <= |masked;
    end
    assign irq_o = irq_q;

    always_comb begin
        case (reg_addr_i)
            RA_MASK: reg_rdata_o = mask_q;
            RA_RAW:  reg_rdata_o = raw_q;
            RA_MSKD: reg_rdata_o = masked;
            RA_THR:  reg_rdata_o = {{PAD_W{1'b0}}, thr_q};
            default: reg_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk
    import evt_irq_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [N_EVT-1:0] evt_i,
    input logic [CNT_W-1:0] rx_fill_i,
    input logic [CNT_W-1:0] thr_q,
    input logic [N_EVT-1:0] raw_q,
    input logic [N_EVT-1:0] mask_q,
    input logic [N_EVT-1:0] clr_vec,
    input logic [N_EVT-1:0] set_vec,
    input logic             lvl_hit,
    input logic             irq_o
);
    AST_EVT_LATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_i != '0) |=> ((raw_q & $past(evt_i)) == $past(evt_i))); // R2

    AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((raw_q & ~$past(raw_q) & ~$past(set_vec)) == '0)); // R2

    AST_UNCLEARED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (($past(raw_q) & ~$past(clr_vec) & ~raw_q) == '0)); // R6

    AST_SET_BEATS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((set_vec & clr_vec) != '0) |=> ((raw_q & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec))); // R7

    AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((raw_q & mask_q) == '0) |=> !irq_o); // R5

    AST_IRQ_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((raw_q & mask_q) != '0) |=> irq_o); // R5

    AST_LVL_CMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lvl_hit |-> (rx_fill_i >= thr_q)); // R9

    AST_LVL_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lvl_hit |=> !lvl_hit); // R9
endmodule

bind evt_irq_ctrl evt_irq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt_i),
    .rx_fill_i (rx_fill_i),
    .thr_q     (thr_q),
    .raw_q     (raw_q),
    .mask_q    (mask_q),
    .clr_vec   (clr_vec),
    .set_vec   (set_vec),
    .lvl_hit   (lvl_hit),
    .irq_o     (irq_o)
);

// File: tb/tb_evt_irq_ctrl.sv
`timescale 1ns/100ps
module tb_evt_irq_ctrl;
    import evt_irq_pkg::*;

    localparam int CNT_W = 4;

    logic              clk = 1'b0;
    logic              rst_ni = 1'b0;
    logic [N_EVT-1:0]  evt_i = '0;
    logic [CNT_W-1:0]  rx_fill_i = '0;
    logic [ADDR_W-1:0] reg_addr_i = '0;
    logic              reg_wr_i = 1'b0;
    logic [N_EVT-1:0]  reg_wdata_i = '0;
    logic [N_EVT-1:0]  reg_rdata_o;
    logic              irq_o;

    always #2.5 clk = ~clk;

    evt_irq_ctrl #(.CNT_W(CNT_W)) dut (
        .clk_i       (clk),
        .rst_ni      (rst_ni),
        .evt_i       (evt_i),
        .rx_fill_i   (rx_fill_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wr_i    (reg_wr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .irq_o       (irq_o)
    );

    typedef struct {
        bit               is_irq;
        logic [N_EVT-1:0] exp;
        string            tag;
    } exp_t;

    exp_t sb[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;

    // monitor: compares at the falling edge, away from the active edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t it;
            logic [N_EVT-1:0] act;
            it  = sb.pop_front();
            act = it.is_irq ? {{(N_EVT-1){1'b0}}, irq_o} : reg_rdata_o;
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
        evt_i    = '0;
        reg_wr_i = 1'b0;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [N_EVT-1:0] d);
        reg_addr_i  = a;
        reg_wdata_i = d;
        reg_wr_i    = 1'b1;
        tick();
    endtask

    task automatic pulse(input logic [N_EVT-1:0] v);
        evt_i = v;
        tick();
    endtask

    task automatic chk_rd(input logic [ADDR_W-1:0] a, input logic [N_EVT-1:0] e, input string tag);
        exp_t it;
        reg_addr_i = a;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb.push_back(it);
        tick();
    endtask

    task automatic chk_irq(input logic e, input string tag);
        exp_t it;
        it.is_irq = 1'b1; it.exp = {{(N_EVT-1){1'b0}}, e}; it.tag = tag;
        sb.push_back(it);
        tick();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_ni = 1'b1;
        tick();

        chk_rd(RA_MASK, 9'h000, "R1 mask reset");
        chk_rd(RA_RAW,  9'h000, "R1 raw reset");
        chk_rd(RA_THR,  9'h001, "R1 threshold reset");
        chk_irq(1'b0, "R1 irq reset");

        wr(RA_MASK, 9'h0A5);
        chk_rd(RA_MASK, 9'h0A5, "R10 mask readback");
        wr(RA_THR, 9'h003);
        chk_rd(RA_THR, 9'h003, "R10 threshold readback");
        wr(RA_MASK, 9'h000);

        pulse(9'h0C1);
        chk_rd(RA_RAW, 9'h0C1, "R2 R3 raw with mask off");
        chk_irq(1'b0, "R5 masked-off sources");
        chk_rd(RA_MSKD, 9'h000, "R4 masked view empty");

        wr(RA_MASK, 9'h040);
        chk_rd(RA_MSKD, 9'h040, "R4 masked view");
        chk_irq(1'b1, "R5 irq raised");

        wr(RA_CLR, 9'h040);
        chk_rd(RA_RAW, 9'h081, "R6 selective clear");
        chk_rd(RA_CLR, 9'h000, "R6 clear reads zero");
        chk_irq(1'b0, "R5 irq dropped");

        pulse(9'h040);
        chk_rd(RA_RAW, 9'h0C1, "R8 relatch after clear");

        // same-cycle set and clear
        reg_addr_i  = RA_CLR;
        reg_wdata_i = 9'h181;
        reg_wr_i    = 1'b1;
        evt_i       = 9'h100;
        tick();
        chk_rd(RA_RAW, 9'h140, "R7 set wins");

        wr(RA_RAW, 9'h1FF);
        wr(RA_MSKD, 9'h1FF);
        chk_rd(RA_RAW, 9'h140, "R11 read-only write ignored");
        chk_rd(RA_MASK, 9'h040, "R11 mask untouched");
        chk_rd(3'd6, 9'h000, "R11 unused address");

        wr(RA_CLR, 9'h1FF);
        rx_fill_i = 4'd2;
        tick();
        chk_rd(RA_RAW, 9'h000, "R9 below threshold");
        rx_fill_i = 4'd3;
        tick();
        chk_rd(RA_RAW, 9'h020, "R9 threshold reached");
        wr(RA_CLR, 9'h020);
        chk_rd(RA_RAW, 9'h000, "R9 no re-raise while above");
        rx_fill_i = 4'd5;
        tick();
        chk_rd(RA_RAW, 9'h000, "R9 rising further no event");
        rx_fill_i = 4'd1;
        tick();
        rx_fill_i = 4'd4;
        tick();
        chk_rd(RA_RAW, 9'h020, "R9 rearmed crossing");

        wr(RA_MASK, 9'h1FF);
        tick();
        chk_irq(1'b1, "R5 irq from level event");
        tick();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule